// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static RAM Model

This block stands in for an asynchronous 16-bit-wide static RAM when a memory controller is tested. It takes the address, the five active-low strobes (chip enable, write enable, output enable, low-byte select, high-byte select) and a data-in bus. It returns a data-out bus together with one drive enable per byte lane, which replaces the high-impedance state of a shared bidirectional bus. Analog levels, standby current and real propagation delays are not modelled.

A free-running sample clock registers every input once per cycle. Reads, output gating and write commits are all worked out from those samples. A write stays open as long as both chip enable and write enable are sampled low. It is committed at the first sample where that condition has gone false. The data and lane mask committed are those of the last sample in which the write was still open. The stored depth is set by a parameter. Address bits above the stored range are ignored, so the array can be made smaller for synthesis.

Top module: `async_sram_model`

## Requirements
- R1: While reset is asserted and just after it, both lane drive enables are 0 and the address error flag is 0.
- R2: When chip enable is sampled high, both lane drive enables are 0 and nothing is written to the array, whatever write enable, output enable and the byte selects are.
- R3: A read is chip enable low, write enable high and output enable low. During a read, lane 0 (data bits 7:0, drive enable bit 0) is driven only when the low-byte select is low. Lane 1 (bits 15:8, drive enable bit 1) is driven only when the high-byte select is low. A driven lane carries the stored byte. A lane that is not driven shows 0 on the data-out bus.
- R4: With chip enable low and both write enable and output enable high, both lane drive enables are 0.
- R5: While write enable is sampled low, both lane drive enables are 0 whatever output enable is. Output enable has no effect on a write.
- R6: A write is committed at the first sample in which chip enable or write enable has risen. A rise of either strobe ends it. Only lanes whose byte select was low in the last open sample are written. The other lane keeps its earlier contents.
- R7: If the data changes while a write is open, the data sampled last before the write ends is the value stored.
- R8: The address error flag sets when the address changes between two consecutive samples that both have the write open. It then stays set until reset.
- R9: Address bits at and above the array index width are ignored. Two addresses that differ only in those bits reach the same word.
- R10: Outputs follow the inputs sampled at the latest clock edge. A read applied between edges shows its data and drive enables only after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 16 | Word address |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| lb_n | input | 1 | Low-byte select, active low |
| ub_n | input | 1 | High-byte select, active low |
| din | input | 16 | Write data |
| dout | output | 16 | Read data; zero in lanes that are not driven |
| dq_oe | output | 2 | Per-lane drive enable, bit 0 for bits 7:0 |
| addr_err | output | 1 | Sticky flag: address moved during an open write |

## Verification
The bench builds the model with an array index width of 4, which gives 16 stored words. At that size, an address carrying set bits above bit 3 lands on a low word that was written earlier. This makes the aliasing rule of R9 observable with only a few writes. The address width and lane layout stay at their default values of 16 bits and two 8-bit lanes, so every byte-select combination and every way of ending a write is exercised at full data width.

// File: rtl/async_sram_pkg.sv
package async_sram_pkg;
    parameter int SRAM_AW     = 16;
    parameter int SRAM_LANE_W = 8;
    parameter int SRAM_LANES  = 2;
    parameter int SRAM_DW     = SRAM_LANE_W * SRAM_LANES;

    typedef struct packed {
        logic                  ce_n;
        logic                  we_n;
        logic                  oe_n;
        logic [SRAM_LANES-1:0] bsel_n;
        logic [SRAM_AW-1:0]    addr;
        logic [SRAM_DW-1:0]    din;
        logic                  err;
    } smp_state_t;

    localparam smp_state_t SMP_RESET = '{
        ce_n:   1'b1,
        we_n:   1'b1,
        oe_n:   1'b1,
        bsel_n: '1,
        addr:   '0,
        din:    '0,
        err:    1'b0
    };
endpackage

// File: rtl/sram_sampler.sv
module sram_sampler
    import async_sram_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SRAM_AW-1:0]    addr,
    input  logic                  ce_n,
    input  logic                  we_n,
    input  logic                  oe_n,
    input  logic [SRAM_LANES-1:0] bsel_n,
    input  logic [SRAM_DW-1:0]    din,
    output logic [SRAM_AW-1:0]    rd_addr,
    output logic                  rd_ok,
    output logic [SRAM_LANES-1:0] rd_bsel_n,
    output logic                  cm_en,
    output logic [SRAM_AW-1:0]    cm_addr,
    output logic [SRAM_DW-1:0]    cm_data,
    output logic [SRAM_LANES-1:0] cm_mask,
    output logic                  err
);
    smp_state_t st_d, st_q;
    logic       wr_now;
    logic       wr_was;

    always_comb begin
        wr_now      = !ce_n && !we_n;
        wr_was      = !st_q.ce_n && !st_q.we_n;
        st_d        = st_q;
        st_d.ce_n   = ce_n;
        st_d.we_n   = we_n;
        st_d.oe_n   = oe_n;
        st_d.bsel_n = bsel_n;
        st_d.addr   = addr;
        st_d.din    = din;
        st_d.err    = st_q.err || (wr_was && wr_now && (addr != st_q.addr));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SMP_RESET;
        else        st_q <= st_d;
    end

    assign rd_addr   = st_q.addr;
    assign rd_ok     = !st_q.ce_n && st_q.we_n && !st_q.oe_n;
    assign rd_bsel_n = st_q.bsel_n;
    assign cm_en     = wr_was && !wr_now;
    assign cm_addr   = st_q.addr;
    assign cm_data   = st_q.din;
    assign cm_mask   = ~st_q.bsel_n;
    assign err       = st_q.err;
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array
    import async_sram_pkg::*;
#(
    parameter int MEM_AW = 10
) (
    input  logic                  clk,
    input  logic [SRAM_AW-1:0]    rd_addr,
    output logic [SRAM_DW-1:0]    rd_data,
    input  logic                  wr_en,
    input  logic [SRAM_AW-1:0]    wr_addr,
    input  logic [SRAM_DW-1:0]    wr_data,
    input  logic [SRAM_LANES-1:0] wr_mask
);
    localparam int DEPTH = 1 << MEM_AW;

    logic [MEM_AW-1:0] rd_idx;
    logic [MEM_AW-1:0] wr_idx;

    assign rd_idx = rd_addr[MEM_AW-1:0];
    assign wr_idx = wr_addr[MEM_AW-1:0];

    for (genvar g = 0; g < SRAM_LANES; g++) begin : g_lane
        logic [SRAM_LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[g])
                mem[wr_idx] <= wr_data[g*SRAM_LANE_W +: SRAM_LANE_W];
        end

        assign rd_data[g*SRAM_LANE_W +: SRAM_LANE_W] = mem[rd_idx];
    end
endmodule

// File: rtl/sram_lane_drive.sv
module sram_lane_drive
    import async_sram_pkg::*;
(
    input  logic                  rd_ok,
    input  logic [SRAM_LANES-1:0] bsel_n,
    input  logic [SRAM_DW-1:0]    rd_data,
    output logic [SRAM_DW-1:0]    dout,
    output logic [SRAM_LANES-1:0] lane_oe
);
    for (genvar g = 0; g < SRAM_LANES; g++) begin : g_drv
        assign lane_oe[g] = rd_ok && !bsel_n[g];
        assign dout[g*SRAM_LANE_W +: SRAM_LANE_W] =
            lane_oe[g] ? rd_data[g*SRAM_LANE_W +: SRAM_LANE_W] : '0;
    end
endmodule

// File: rtl/async_sram_model.sv
module async_sram_model
    import async_sram_pkg::*;
#(
    parameter int MEM_AW = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SRAM_AW-1:0]    addr,
    input  logic                  ce_n,
    input  logic                  we_n,
    input  logic                  oe_n,
    input  logic                  lb_n,
    input  logic                  ub_n,
    input  logic [SRAM_DW-1:0]    din,
    output logic [SRAM_DW-1:0]    dout,
    output logic [SRAM_LANES-1:0] dq_oe,
    output logic                  addr_err
);
    logic [SRAM_LANES-1:0] bsel_n;
    logic [SRAM_AW-1:0]    rd_addr;
    logic                  rd_ok;
    logic [SRAM_LANES-1:0] rd_bsel_n;
    logic                  cm_en;
    logic [SRAM_AW-1:0]    cm_addr;
    logic [SRAM_DW-1:0]    cm_data;
    logic [SRAM_LANES-1:0] cm_mask;
    logic [SRAM_DW-1:0]    rd_data;

    assign bsel_n = {ub_n, lb_n};

    sram_sampler u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .ce_n      (ce_n),
        .we_n      (we_n),
        .oe_n      (oe_n),
        .bsel_n    (bsel_n),
        .din       (din),
        .rd_addr   (rd_addr),
        .rd_ok     (rd_ok),
        .rd_bsel_n (rd_bsel_n),
        .cm_en     (cm_en),
        .cm_addr   (cm_addr),
        .cm_data   (cm_data),
        .cm_mask   (cm_mask),
        .err       (addr_err)
    );

    sram_lane_array #(.MEM_AW(MEM_AW)) u_arr (
        .clk     (clk),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wr_en   (cm_en),
        .wr_addr (cm_addr),
        .wr_data (cm_data),
        .wr_mask (cm_mask)
    );

    sram_lane_drive u_drv (
        .rd_ok   (rd_ok),
        .bsel_n  (rd_bsel_n),
        .rd_data (rd_data),
        .dout    (dout),
        .lane_oe (dq_oe)
    );
endmodule

// File: rtl/async_sram_model_chk.sv
module async_sram_model_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] addr,
    input logic        ce_n,
    input logic        we_n,
    input logic        oe_n,
    input logic        lb_n,
    input logic        ub_n,
    input logic [1:0]  dq_oe,
    input logic        addr_err
);
    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (dq_oe == 2'b00 && !addr_err); // R1
        end
    end

    AST_DESEL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (dq_oe == 2'b00)); // R2

    AST_LOW_LANE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && we_n && !oe_n && !lb_n) |=> dq_oe[0]); // R3

    AST_LOW_LANE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        lb_n |=> !dq_oe[0]); // R3

    AST_HIGH_LANE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ub_n |=> !dq_oe[1]); // R3

    AST_OE_HIGH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> (dq_oe == 2'b00)); // R4

    AST_WRITE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |=> (dq_oe == 2'b00)); // R5

    AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !we_n) ##1 (!ce_n && !we_n && addr != $past(addr)) |=> addr_err); // R8

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |=> addr_err); // R8
endmodule

bind async_sram_model async_sram_model_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .ce_n     (ce_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .lb_n     (lb_n),
    .ub_n     (ub_n),
    .dq_oe    (dq_oe),
    .addr_err (addr_err)
);

// File: tb/async_sram_model_bench.sv
module async_sram_model_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic [1:0]  dq_oe;
    logic        addr_err;
    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    async_sram_model #(.MEM_AW(4)) u_async_sram_model (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .we_n(we_n),
        .oe_n(oe_n), .lb_n(lb_n), .ub_n(ub_n), .din(din), .dout(dout),
        .dq_oe(dq_oe), .addr_err(addr_err)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(logic c, logic w, logic o, logic l, logic u,
                       logic [15:0] a, logic [15:0] d);
        @(negedge clk);
        ce_n = c; we_n = w; oe_n = o; lb_n = l; ub_n = u; addr = a; din = d;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        cyc(1, 1, 1, 1, 1, 16'h0, 16'h0);
    endtask

    task automatic wr(logic [15:0] a, logic [15:0] d, logic l, logic u);
        cyc(0, 0, 1, l, u, a, d);
        cyc(0, 1, 1, 1, 1, a, 16'h0);
    endtask

    task automatic rd(logic [15:0] a, logic l, logic u);
        cyc(0, 1, 0, l, u, a, 16'h0);
    endtask

    task automatic t_reset();
        check("R1 dq_oe in reset", 32'(dq_oe), 32'h0);
        check("R1 err in reset", 32'(addr_err), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        idle();
        check("R1 dq_oe after reset", 32'(dq_oe), 32'h0);
        check("R1 err after reset", 32'(addr_err), 32'h0);
    endtask

    task automatic t_read_write();
        wr(16'h0002, 16'hA5C3, 0, 0);
        rd(16'h0002, 0, 0);
        check("R3 full read oe", 32'(dq_oe), 32'h3);
        check("R3 full read data", 32'(dout), 32'hA5C3);
        rd(16'h0002, 0, 1);
        check("R3 low lane oe", 32'(dq_oe), 32'h1);
        check("R3 low lane data", 32'(dout), 32'h00C3);
        rd(16'h0002, 1, 0);
        check("R3 high lane oe", 32'(dq_oe), 32'h2);
        check("R3 high lane data", 32'(dout), 32'hA500);
    endtask

    task automatic t_byte_write();
        wr(16'h0007, 16'hAAAA, 0, 0);
        wr(16'h0007, 16'h1155, 0, 1);
        rd(16'h0007, 0, 0);
        check("R6 low lane only write", 32'(dout), 32'hAA55);
        cyc(0, 0, 1, 1, 0, 16'h0007, 16'h3377);
        cyc(1, 0, 1, 1, 0, 16'h0007, 16'h0000);
        rd(16'h0007, 0, 0);
        check("R6 high lane write ended by ce", 32'(dout), 32'h3355);
    endtask

    task automatic t_deselect();
        wr(16'h0005, 16'h1234, 0, 0);
        cyc(1, 0, 0, 0, 0, 16'h0005, 16'hFFFF);
        check("R2 deselect oe", 32'(dq_oe), 32'h0);
        cyc(1, 1, 0, 0, 0, 16'h0005, 16'hFFFF);
        check("R2 deselect read oe", 32'(dq_oe), 32'h0);
        rd(16'h0005, 0, 0);
        check("R2 no write while deselected", 32'(dout), 32'h1234);
    endtask

    task automatic t_outputs_off();
        cyc(0, 1, 1, 0, 0, 16'h0005, 16'h0);
        check("R4 oe high lanes off", 32'(dq_oe), 32'h0);
        check("R4 oe high dout", 32'(dout), 32'h0);
        cyc(0, 0, 0, 0, 0, 16'h0009, 16'h6E6E);
        check("R5 write lanes off with oe low", 32'(dq_oe), 32'h0);
        cyc(0, 1, 1, 1, 1, 16'h0009, 16'h0);
        rd(16'h0009, 0, 0);
        check("R5 write with oe low stored", 32'(dout), 32'h6E6E);
    endtask

    task automatic t_last_data();
        cyc(0, 0, 1, 0, 0, 16'h000B, 16'h1111);
        cyc(0, 0, 1, 0, 0, 16'h000B, 16'h2222);
        cyc(0, 0, 1, 0, 0, 16'h000B, 16'h3C3C);
        cyc(0, 1, 1, 1, 1, 16'h000B, 16'hFFFF);
        rd(16'h000B, 0, 0);
        check("R7 last data stored", 32'(dout), 32'h3C3C);
        check("R8 steady address no error", 32'(addr_err), 32'h0);
    endtask

    task automatic t_alias();
        wr(16'h0013, 16'hBEEF, 0, 0);
        rd(16'h0003, 0, 0);
        check("R9 alias read", 32'(dout), 32'hBEEF);
        wr(16'hFFF3, 16'h0F0F, 0, 0);
        rd(16'h0003, 0, 0);
        check("R9 alias overwrite", 32'(dout), 32'h0F0F);
    endtask

    task automatic t_latency();
        wr(16'h000C, 16'h5A5A, 0, 0);
        idle();
        @(negedge clk);
        ce_n = 0; we_n = 1; oe_n = 0; lb_n = 0; ub_n = 0; addr = 16'h000C;
        #1;
        check("R10 no change before edge", 32'(dq_oe), 32'h0);
        @(posedge clk);
        #1;
        check("R10 oe after edge", 32'(dq_oe), 32'h3);
        check("R10 data after edge", 32'(dout), 32'h5A5A);
    endtask

    task automatic t_addr_err();
        cyc(0, 0, 1, 0, 0, 16'h0008, 16'h0001);
        check("R8 no error yet", 32'(addr_err), 32'h0);
        cyc(0, 0, 1, 0, 0, 16'h0009, 16'h0001);
        check("R8 error set", 32'(addr_err), 32'h1);
        cyc(0, 1, 1, 1, 1, 16'h0009, 16'h0);
        idle();
        idle();
        check("R8 error sticky", 32'(addr_err), 32'h1);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 reset clears error", 32'(addr_err), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        t_read_write();
        t_byte_write();
        t_deselect();
        t_outputs_off();
        t_last_data();
        t_alias();
        t_latency();
        t_addr_err();
        idle();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule